// File: doc/BRIEF.md
# Paged Register Bank Two-Wire Slave

This block is a slave on a two-wire serial bus (I2C). It answers a host that reaches a bank of 8-bit registers organised as pages of 128 entries. The page in use is held inside the block, and register 0 of every page selects it. The storage for all other registers lies outside the block. The block reaches that storage through a simple port: page, register index, write data, a one-cycle write strobe, and read data that the storage returns combinationally.

The host opens a write transfer. Its first data byte loads the register pointer. Each later byte is stored at the pointer, and the pointer then steps forward. To read, the host writes the pointer, issues a repeated START and addresses the block for reading. Bytes then stream out from the pointer onward until the host answers with NACK. The general-call address (0x00) is acknowledged only while an enable input, driven from a register bit, is high. Both bus lines are sampled into the system clock domain. The block drives SDA only by pulling it low, through an output enable. It never stretches SCL and never acts as a master.

Top module: `i2c_pg_slave`

## Requirements
- R1: After reset the selected page is 0, SDA is released (`sda_oe` = 0) and no write strobe is issued.
- R2: An address byte whose upper seven bits equal the parameter `SLV_ADDR` is acknowledged by pulling SDA low during the ninth clock. The lowest bit is 0 for a write and 1 for a read. Any other address is not acknowledged, and the bytes that follow until the next START cause no register access.
- R3: The address byte 0x00 (general call, write) is acknowledged only while `gcall_en` is 1. The data bytes that follow are handled like those of a normal write. The byte 0x01 is never acknowledged.
- R4: The first data byte after a write address loads its low seven bits into the register pointer and issues no write strobe.
- R5: Each later write byte to a non-zero pointer gives one `reg_we` pulse of a single cycle, carrying the current page, the pointer and the byte. The pointer then increases by one, modulo 128, so index 127 is followed by index 0.
- R6: Register index 0 on any page is the page select. Writing it changes `reg_page` and never strobes the storage. Reading it returns the current page.
- R7: A read transfer sends bytes MSB first, starting from the current pointer. The pointer increases by one after each byte.
- R8: When the host answers a read byte with NACK (SDA high in the ninth clock), the block stops sending and keeps SDA released. A STOP always releases SDA.
- R9: A repeated START without a STOP before it is accepted as a new address phase, and the register pointer keeps its value across it.
- R10: SDA as driven by the block changes only after a falling SCL edge, a START or a STOP, so its level is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| gcall_en | input | 1 | Enables the general-call acknowledge |
| reg_page | output | PAGE_W | Selected page |
| reg_addr | output | 7 | Register pointer within the page |
| reg_wdata | output | 8 | Data for a storage write |
| reg_we | output | 1 | Storage write strobe, one cycle |
| reg_rdata | input | 8 | Storage read data for `reg_page`/`reg_addr` |

## Verification
Write bursts of several bytes start at a middle index, which shows whether the pointer byte is kept apart from the data bytes and whether later bytes step forward. A burst that crosses index 127 shows the wrap onto the page-select register. Combined write-then-read transfers, with acknowledged and unacknowledged last bytes, show whether a repeated START keeps the pointer and whether a read ends cleanly on NACK. A foreign address and the general-call address, tried with the enable low and high and with the read bit set, show the three outcomes of address decoding.

// File: rtl/i2c_pg_pkg.sv
package i2c_pg_pkg;

  localparam int REG_AW = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_END, ST_ACK, ST_WRITE,
    ST_WR_END, ST_READ, ST_READ_END, ST_RACK, ST_RACK_GO
  } eng_state_e;

  // Address byte decode: own address in either direction, or general call write.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own,
                                    input logic gc_en);
    return (b[7:1] == own) || (gc_en && (b == 8'h00));
  endfunction

  // Pointer step inside one page, wrapping at the page size.
  function automatic logic [REG_AW-1:0] ptr_step(input logic [REG_AW-1:0] p);
    return p + {{(REG_AW-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/i2c_pg_linesync.sv
module i2c_pg_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/i2c_pg_engine.sv
module i2c_pg_engine
  import i2c_pg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h18,
  parameter int         PAGE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              gcall_en,
  input  logic [7:0]        reg_rdata,
  output logic              sda_oe,
  output logic [PAGE_W-1:0] reg_page,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we
);
  eng_state_e        st;
  logic [2:0]        bitcnt;
  logic [7:0]        shreg, tx, page_byte, byte_out;
  logic [REG_AW-1:0] ptr;
  logic              rd_mode, first;

  always_comb begin
    page_byte = '0;
    page_byte[PAGE_W-1:0] = reg_page;
  end
  assign byte_out = (ptr == '0) ? page_byte : reg_rdata;
  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      rd_mode <= 1'b0; first <= 1'b0; sda_oe <= 1'b0;
      reg_page <= '0; reg_wdata <= '0; reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr_step(ptr);
      if (start_det) begin
        st <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WRITE: if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) st <= (st == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
          end
          ST_ADDR_END: if (scl_fall) begin
            if (addr_hit(shreg, SLV_ADDR, gcall_en)) begin
              sda_oe <= 1'b1; rd_mode <= shreg[0]; first <= !shreg[0]; st <= ST_ACK;
            end else st <= ST_IDLE;
          end
          ST_WR_END: if (scl_fall) begin
            sda_oe <= 1'b1; st <= ST_ACK;
            if (first) begin
              ptr <= shreg[REG_AW-1:0]; first <= 1'b0;
            end else if (ptr == '0) begin
              reg_page <= shreg[PAGE_W-1:0]; ptr <= ptr_step(ptr);
            end else begin
              reg_we <= 1'b1; reg_wdata <= shreg;
            end
          end
          ST_ACK, ST_RACK_GO: if (scl_fall) begin
            bitcnt <= '0;
            if (st == ST_RACK_GO || rd_mode) begin
              tx <= byte_out; sda_oe <= !byte_out[7]; ptr <= ptr_step(ptr); st <= ST_READ;
            end else begin
              sda_oe <= 1'b0; st <= ST_WRITE;
            end
          end
          ST_READ: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) st <= ST_READ_END;
            end
            if (scl_fall) begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= !tx[6];
            end
          end
          ST_READ_END: if (scl_fall) begin
            sda_oe <= 1'b0; st <= ST_RACK;
          end
          ST_RACK: if (scl_rise) st <= sda_s ? ST_IDLE : ST_RACK_GO;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_pg_slave.sv
module i2c_pg_slave
  import i2c_pg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h18,
  parameter int         PAGE_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              gcall_en,
  output logic [PAGE_W-1:0] reg_page,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_pg_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_pg_engine #(.SLV_ADDR(SLV_ADDR), .PAGE_W(PAGE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .gcall_en(gcall_en), .reg_rdata(reg_rdata), .sda_oe(sda_oe),
    .reg_page(reg_page), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we)
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_pg_slave_chk.sv
module i2c_pg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [6:0] reg_addr
);
  // R10
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == $past(reg_addr) + 7'd1));

  // R6
  no_page_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr != 7'd0));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_pg_slave i2c_pg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/i2c_pg_slave_bench.sv
`timescale 1ns/1ps
module i2c_pg_slave_bench;
  localparam int H = 25;
  localparam logic [7:0] WA = 8'h30, RA = 8'h31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, gcall_en = 1'b0;
  logic sda_oe, reg_we, sda_line;
  logic [7:0] reg_page, reg_wdata, reg_rdata;
  logic [6:0] reg_addr;
  logic [7:0] mem [0:511];
  int checks = 0, errors = 0, wr_count = 0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_pg_slave u_i2c_pg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .gcall_en(gcall_en), .reg_page(reg_page), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[{reg_page[1:0], reg_addr}];
  always @(posedge clk) if (reg_we) begin
    mem[{reg_page[1:0], reg_addr}] <= reg_wdata;
    wr_count <= wr_count + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hwait(H); m_scl = 1'b1; hwait(H);
    m_sda = 1'b0; hwait(H); m_scl = 1'b0; hwait(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hwait(H); m_scl = 1'b1; hwait(H); m_sda = 1'b1; hwait(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hwait(H); m_scl = 1'b1; hwait(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; hwait(H); m_scl = 1'b1; hwait(H / 2);
    ack = ~sda_line; hwait(H - H / 2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic early;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hwait(H); m_scl = 1'b1; hwait(H / 2);
      b[i] = sda_line; early = sda_line;
      hwait(H - H / 2 - 1);
      chk("R10 sda stable while scl high", sda_line, early);
      hwait(1); m_scl = 1'b0;
    end
    m_sda = ~give_ack; hwait(H); m_scl = 1'b1; hwait(H); m_scl = 1'b0;
    hwait(2); m_sda = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 sda released", sda_oe, 0);
    chk("R1 no strobe", reg_we, 0);
    chk("R1 page zero", reg_page, 0);
  endtask

  task automatic t_write_burst;
    logic a;
    int base;
    base = wr_count;
    bus_start; send_byte(WA, a); chk("R2 own write address ack", a, 1);
    send_byte(8'h05, a); chk("R4 pointer byte ack", a, 1);
    send_byte(8'hA1, a); send_byte(8'hB2, a); send_byte(8'hC3, a);
    bus_stop;
    chk("R5 reg5", mem[5], 8'hA1); chk("R5 reg6", mem[6], 8'hB2);
    chk("R5 reg7", mem[7], 8'hC3);
    chk("R4 strobe count", wr_count - base, 3);
  endtask

  task automatic t_read_rstart;
    logic a; logic [7:0] d;
    bus_start; send_byte(WA, a); send_byte(8'h06, a);
    bus_start; send_byte(RA, a); chk("R9 repeated start read ack", a, 1);
    recv_byte(1'b1, d); chk("R7 first read byte", d, 8'hB2);
    recv_byte(1'b1, d); chk("R7 second read byte", d, 8'hC3);
    recv_byte(1'b0, d); chk("R7 third read byte", d, 8'h5A);
    hwait(H); chk("R8 released after nack", sda_oe, 0);
    bus_stop; chk("R8 released after stop", sda_oe, 0);
  endtask

  task automatic t_page;
    logic a; logic [7:0] d;
    bus_start; send_byte(WA, a); send_byte(8'h00, a);
    send_byte(8'h02, a); chk("R6 page write ack", a, 1);
    send_byte(8'h44, a); bus_stop;
    chk("R6 page selected", reg_page, 2);
    chk("R5 page2 reg1", mem[257], 8'h44);
    chk("R6 page0 reg0 untouched", mem[0], 8'hEE);
    bus_start; send_byte(WA, a); send_byte(8'h00, a);
    bus_start; send_byte(RA, a); recv_byte(1'b0, d); bus_stop;
    chk("R6 read page select", d, 8'h02);
  endtask

  task automatic t_wrap;
    logic a;
    bus_start; send_byte(WA, a); send_byte(8'h7F, a);
    send_byte(8'h99, a); send_byte(8'h01, a); bus_stop;
    chk("R5 reg127 written", mem[383], 8'h99);
    chk("R5 wrap onto page select", reg_page, 1);
  endtask

  task automatic t_bad_addr;
    logic a;
    int base;
    base = wr_count;
    bus_start; send_byte(8'h52, a); chk("R2 foreign address nack", a, 0);
    send_byte(8'h03, a); send_byte(8'h66, a); bus_stop;
    chk("R2 foreign transfer no strobe", wr_count - base, 0);
    chk("R2 page kept", reg_page, 1);
  endtask

  task automatic t_gcall;
    logic a;
    gcall_en = 1'b0;
    bus_start; send_byte(8'h00, a); bus_stop; chk("R3 gcall disabled nack", a, 0);
    gcall_en = 1'b1;
    bus_start; send_byte(8'h01, a); bus_stop; chk("R3 gcall read nack", a, 0);
    bus_start; send_byte(8'h00, a); chk("R3 gcall enabled ack", a, 1);
    send_byte(8'h10, a); send_byte(8'h77, a); bus_stop;
    chk("R3 gcall write stored", mem[144], 8'h77);
    gcall_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    mem[0] = 8'hEE; mem[8] = 8'h5A;
    hwait(10); rst_n = 1'b1; hwait(10);
    t_reset;
    t_write_burst;
    t_read_rstart;
    t_page;
    t_wrap;
    t_bad_addr;
    t_gcall;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule